// File: doc/BRIEF.md
# Command Decoder and Error Status Unit

This block sits behind the command register of a register-mapped measurement slave. When a command byte is written it checks the code. It then turns the code into a single-cycle request pulse for the part of the chip that carries the operation out. The requests are software reboot, mains recalibration, charge-counter clear, parameter save, period latch and factory restore. Flash programming and the measurement pipeline are outside this block. It only raises the requests.

The block also keeps the readable health state of the slave. This is an 8-bit error code, a status byte and a data-valid byte. Three kinds of fault all set one parameter-error code: a command code that is not defined, a register write that the register file has refused, and a broadcast command that may not run on broadcast. The error code stays set until the block is reset. The not-ready code is reported from reset until the measurement side signals that its first window is done.

Top module: `cmd_status_unit`

## Requirements
- R1: While and after reset, before any other input event, all request pulses are low. The error register reads 0xFC, the status byte reads 0x02 and the valid byte reads 0x00.
- R2: A strobed command with code 0x01, 0x02, 0x05, 0x26, 0x27 or 0xAA raises exactly one pulse, for exactly one cycle, in the cycle after the strobe. The pulses are go_reset, go_recal, go_charge_clr, go_save, go_latch and go_factory, in that order of code.
- R3: Codes 0x00 (no operation) and 0x03 (debug toggle) are accepted. They raise no pulse and leave the error register unchanged.
- R4: Any other strobed code raises no pulse. It loads 0xFE into the error register in the cycle after the strobe.
- R5: A wr_reject pulse loads 0xFE into the error register in the following cycle.
- R6: With cmd_bcast high, codes 0x00, 0x01 and 0x27 behave as in R2 and R3. Any other code raises no pulse and loads 0xFE.
- R7: A new fault overwrites the code already held, including the not-ready code. A held 0xFE is not cleared by later successful commands or by window completion. Only reset clears it.
- R8: win_done sets bit 0 of the valid byte in the next cycle, and the bit stays set until reset. If the error register then holds 0xFC, it becomes 0x00. If a fault arrives in the same cycle as win_done, 0xFE wins.
- R9: Status bit 0 equals valid bit 0. Status bit 1 is high exactly when the error register is nonzero. All other status bits and valid bits 7..1 read 0.
- R10: Every nonzero error code has bit 7 set. No code in 0x01..0xF9 is ever produced.
- R11: With cmd_wr low, no request pulse is raised whatever cmd_code holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe for the command byte |
| cmd_code | input | 8 | Command byte |
| cmd_bcast | input | 1 | Write arrived by broadcast address |
| wr_reject | input | 1 | Register file refused a write (read-only or out of range) |
| win_done | input | 1 | Measurement window completed |
| go_reset | output | 1 | Software reboot request |
| go_recal | output | 1 | Recalibration request |
| go_charge_clr | output | 1 | Charge counter clear request |
| go_save | output | 1 | Parameter save request |
| go_latch | output | 1 | Period latch request |
| go_factory | output | 1 | Factory restore request |
| status_q | output | 8 | Status byte: bit 0 ready, bit 1 error present |
| error_q | output | 8 | Sticky error code |
| valid_q | output | 8 | Data-valid byte, bit 0 |

## Verification
Every result of this block sits one register stage behind its cause. A request pulse shows one cycle after the strobe and is gone one cycle later. The error code, status byte and valid byte take their new values in the cycle after a strobe, a wr_reject pulse or a win_done pulse. The bench drives each stimulus for one cycle on the falling edge. It reads the outputs at the next falling edge, just after the capturing rising edge. It reads the pulses once more a cycle later to confirm they last one cycle only. It also rechecks the error code after later successful commands, which shows that the code holds.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;
  localparam int CODE_W = 8;
  localparam int ACT_N  = 6;

  localparam logic [CODE_W-1:0] ERR_NONE  = 8'h00;
  localparam logic [CODE_W-1:0] ERR_WAIT  = 8'hFC;
  localparam logic [CODE_W-1:0] ERR_PARAM = 8'hFE;

  // request vector bit positions
  localparam int A_REBOOT  = 0;
  localparam int A_RECAL   = 1;
  localparam int A_CHARGE  = 2;
  localparam int A_SAVE    = 3;
  localparam int A_LATCH   = 4;
  localparam int A_FACTORY = 5;

  function automatic logic [ACT_N-1:0] code_to_req(input logic [CODE_W-1:0] c);
    logic [ACT_N-1:0] r;
    r = '0;
    case (c)
      8'h01: r[A_REBOOT]  = 1'b1;
      8'h02: r[A_RECAL]   = 1'b1;
      8'h05: r[A_CHARGE]  = 1'b1;
      8'h26: r[A_SAVE]    = 1'b1;
      8'h27: r[A_LATCH]   = 1'b1;
      8'hAA: r[A_FACTORY] = 1'b1;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic code_known(input logic [CODE_W-1:0] c);
    return (c == 8'h00) || (c == 8'h03) || (code_to_req(c) != '0);
  endfunction

  function automatic logic code_bcast_ok(input logic [CODE_W-1:0] c);
    return (c == 8'h00) || (c == 8'h01) || (c == 8'h27);
  endfunction
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmdstat_pkg::*;
(
  input  logic              wr,
  input  logic [CODE_W-1:0] code,
  input  logic              bcast,
  output logic [ACT_N-1:0]  req_hot,
  output logic              cmd_fault
);
  logic legal;

  always_comb begin
    legal     = code_known(code) && (!bcast || code_bcast_ok(code));
    req_hot   = (wr && legal) ? code_to_req(code) : '0;
    cmd_fault = wr && !legal;
  end
endmodule

// File: rtl/req_pulse_bank.sv
module req_pulse_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end
endmodule

// File: rtl/err_track.sv
module err_track
  import cmdstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_ev,
  input  logic              win_ev,
  output logic [CODE_W-1:0] err_q,
  output logic              ready_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q   <= ERR_WAIT;
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_q | win_ev;
      if (fault_ev)
        err_q <= ERR_PARAM;
      else if (win_ev && err_q == ERR_WAIT)
        err_q <= ERR_NONE;
    end
  end
endmodule

// File: rtl/cmd_status_unit.sv
module cmd_status_unit
  import cmdstat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_code,
  input  logic       cmd_bcast,
  input  logic       wr_reject,
  input  logic       win_done,
  output logic       go_reset,
  output logic       go_recal,
  output logic       go_charge_clr,
  output logic       go_save,
  output logic       go_latch,
  output logic       go_factory,
  output logic [7:0] status_q,
  output logic [7:0] error_q,
  output logic [7:0] valid_q
);
  logic [ACT_N-1:0] req_hot;
  logic [ACT_N-1:0] req_q;
  logic             cmd_fault;
  logic             fault_ev;
  logic             ready_q;

  cmd_decode u_dec (
    .wr(cmd_wr), .code(cmd_code), .bcast(cmd_bcast),
    .req_hot(req_hot), .cmd_fault(cmd_fault)
  );

  assign fault_ev = cmd_fault | wr_reject;

  req_pulse_bank #(.N(ACT_N)) u_pulse (
    .clk(clk), .rst_n(rst_n), .d(req_hot), .q(req_q)
  );

  err_track u_err (
    .clk(clk), .rst_n(rst_n), .fault_ev(fault_ev), .win_ev(win_done),
    .err_q(error_q), .ready_q(ready_q)
  );

  assign go_reset      = req_q[A_REBOOT];
  assign go_recal      = req_q[A_RECAL];
  assign go_charge_clr = req_q[A_CHARGE];
  assign go_save       = req_q[A_SAVE];
  assign go_latch      = req_q[A_LATCH];
  assign go_factory    = req_q[A_FACTORY];

  assign status_q = {6'b0, (error_q != ERR_NONE), ready_q};
  assign valid_q  = {7'b0, ready_q};
endmodule

// File: rtl/cmd_status_chk.sv
module cmd_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [7:0] cmd_code,
  input logic       cmd_bcast,
  input logic       fault_ev,
  input logic [5:0] pulses,
  input logic [7:0] error_q,
  input logic [7:0] valid_q
);
  logic code_defined;
  always_comb begin
    code_defined = (cmd_code == 8'h00) || (cmd_code == 8'h01) || (cmd_code == 8'h02) ||
                   (cmd_code == 8'h03) || (cmd_code == 8'h05) || (cmd_code == 8'h26) ||
                   (cmd_code == 8'h27) || (cmd_code == 8'hAA);
  end

  p_single_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  p_req_needs_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (pulses == '0));

  p_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !code_defined) |=> (error_q == 8'hFE && pulses == '0));

  p_fault_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> (error_q == 8'hFE));

  p_param_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (error_q == 8'hFE) |=> (error_q == 8'hFE));

  p_valid_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q[0] |=> valid_q[0]);

  p_err_bit7_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (error_q != 8'h00) |-> error_q[7]);

  p_bcast_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_bcast && cmd_code != 8'h00 && cmd_code != 8'h01 && cmd_code != 8'h27)
      |=> (pulses == '0 && error_q == 8'hFE));
endmodule

bind cmd_status_unit cmd_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
  .cmd_bcast(cmd_bcast), .fault_ev(fault_ev), .pulses(req_q),
  .error_q(error_q), .valid_q(valid_q)
);

// File: tb/test_cmd_status_unit.sv
`timescale 1ns/1ps
module test_cmd_status_unit;
  logic clk = 1'b0;
  logic rst_n, cmd_wr, cmd_bcast, wr_reject, win_done;
  logic [7:0] cmd_code;
  logic go_reset, go_recal, go_charge_clr, go_save, go_latch, go_factory;
  logic [7:0] status_q, error_q, valid_q;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmd_status_unit i_cmd_status_unit (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .cmd_bcast(cmd_bcast), .wr_reject(wr_reject), .win_done(win_done),
    .go_reset(go_reset), .go_recal(go_recal), .go_charge_clr(go_charge_clr),
    .go_save(go_save), .go_latch(go_latch), .go_factory(go_factory),
    .status_q(status_q), .error_q(error_q), .valid_q(valid_q)
  );

  function automatic logic [5:0] pulses();
    return {go_factory, go_latch, go_save, go_charge_clr, go_recal, go_reset};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_bcast = 1'b0; wr_reject = 1'b0;
    win_done = 1'b0; cmd_code = 8'h00;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // strobe one command, sample after the capturing edge
  task automatic send(input logic [7:0] c, input bit bc);
    cmd_code = c; cmd_bcast = bc; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_bcast = 1'b0;
  endtask

  task automatic window();
    win_done = 1'b1;
    @(negedge clk);
    win_done = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(pulses() == 6'd0, "R1 pulses", pulses(), 0);
    check(error_q == 8'hFC, "R1 error", error_q, 8'hFC);
    check(status_q == 8'h02, "R1/R9 status", status_q, 8'h02);
    check(valid_q == 8'h00, "R1 valid", valid_q, 8'h00);
  endtask

  task automatic t_actions();
    logic [7:0] codes [6] = '{8'h01, 8'h02, 8'h05, 8'h26, 8'h27, 8'hAA};
    do_reset();
    for (int i = 0; i < 6; i++) begin
      send(codes[i], 1'b0);
      check(pulses() == (6'd1 << i), "R2 pulse", pulses(), 1 << i);
      @(negedge clk);
      check(pulses() == 6'd0, "R2 one cycle", pulses(), 0);
    end
    check(error_q == 8'hFC, "R2 no error", error_q, 8'hFC);
  endtask

  task automatic t_benign();
    do_reset();
    send(8'h00, 1'b0);
    check(pulses() == 6'd0, "R3 nop pulse", pulses(), 0);
    send(8'h03, 1'b0);
    check(pulses() == 6'd0, "R3 debug pulse", pulses(), 0);
    check(error_q == 8'hFC, "R3 error kept", error_q, 8'hFC);
  endtask

  task automatic t_window();
    do_reset();
    window();
    check(valid_q == 8'h01, "R8 valid set", valid_q, 1);
    check(error_q == 8'h00, "R8 wait cleared", error_q, 0);
    check(status_q == 8'h01, "R9 status ready", status_q, 1);
    window();
    check(valid_q == 8'h01 && error_q == 8'h00, "R8 repeat window", error_q, 0);
  endtask

  task automatic t_bad_code();
    do_reset();
    send(8'h04, 1'b0);
    check(pulses() == 6'd0, "R4 no pulse", pulses(), 0);
    check(error_q == 8'hFE, "R4/R7 overwrite wait", error_q, 8'hFE);
    check(error_q[7], "R10 bit7", error_q, 8'hFE);
    check(status_q == 8'h02, "R9 status err", status_q, 8'h02);
    window();
    check(error_q == 8'hFE, "R8 window keeps param err", error_q, 8'hFE);
    check(status_q == 8'h03, "R9 status both", status_q, 8'h03);
    send(8'h27, 1'b0);
    check(go_latch == 1'b1, "R2 latch after err", go_latch, 1);
    check(error_q == 8'hFE, "R7 sticky", error_q, 8'hFE);
    @(negedge clk);
    do_reset();
    check(error_q == 8'hFC, "R7 reset clears", error_q, 8'hFC);
  endtask

  task automatic t_reject();
    do_reset();
    window();
    wr_reject = 1'b1;
    @(negedge clk);
    wr_reject = 1'b0;
    check(error_q == 8'hFE, "R5 reject", error_q, 8'hFE);
    check(pulses() == 6'd0, "R5 no pulse", pulses(), 0);
  endtask

  task automatic t_bcast();
    do_reset();
    window();
    send(8'h27, 1'b1);
    check(go_latch == 1'b1 && pulses() == 6'b010000, "R6 bcast latch", pulses(), 6'b010000);
    send(8'h01, 1'b1);
    check(pulses() == 6'b000001, "R6 bcast reset", pulses(), 1);
    send(8'h00, 1'b1);
    check(error_q == 8'h00, "R6 bcast nop", error_q, 0);
    send(8'h26, 1'b1);
    check(pulses() == 6'd0, "R6 bcast save blocked", pulses(), 0);
    check(error_q == 8'hFE, "R6 bcast error", error_q, 8'hFE);
  endtask

  task automatic t_same_cycle();
    do_reset();
    cmd_code = 8'h99; cmd_wr = 1'b1; win_done = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; win_done = 1'b0;
    check(error_q == 8'hFE, "R8 fault beats window", error_q, 8'hFE);
    check(valid_q == 8'h01, "R8 valid with fault", valid_q, 1);
  endtask

  task automatic t_no_strobe();
    do_reset();
    cmd_code = 8'h27;
    @(negedge clk); @(negedge clk);
    check(pulses() == 6'd0, "R11 no strobe", pulses(), 0);
    cmd_code = 8'h44;
    @(negedge clk);
    check(error_q == 8'hFC, "R11 no strobe no error", error_q, 8'hFC);
  endtask

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_bcast = 1'b0; wr_reject = 1'b0;
    win_done = 1'b0; cmd_code = 8'h00;
    t_reset_state();
    t_actions();
    t_benign();
    t_window();
    t_bad_code();
    t_reject();
    t_bcast();
    t_same_cycle();
    t_no_strobe();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule